// File: doc/BRIEF.md
# Shared Interrupt Distributor Register Block

This block is the register file and forwarding stage of an interrupt distributor that serves up to eight CPUs. It holds one enable bit and one 8-bit CPU target mask for each shared interrupt (vectors 32 and up), plus a routing-mode flag. Software reaches it over a simple request bus with one request in flight at a time. Each access carries the ID of the CPU that issues it. A strap input selects between the older distributor model (version 2) and the newer one (version 3). Only the newer model can switch on affinity routing. In that mode the per-interrupt masks are reached through 64-bit routing registers instead of packed byte-wide target words.

Each shared interrupt has an input line. While a line is high and its enable bit is set, the block issues a delivery request. The request carries the interrupt's vector number and its stored CPU mask. Priority, grouping, pending and active state are not modelled. Their register windows accept writes and discard them.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset all enable bits are clear, every target mask is 0xFF, affinity routing is off, and neither a response nor a delivery request is issued.
- R2: A request whose byte offset has bits 1:0 non-zero fails. A request in the routing window 0x6100..0x7FD8 fails unless `req_wide` is 1 (64-bit). A request anywhere else fails unless `req_wide` is 0 (32-bit).
- R3: The following requests fail: any offset with no register; a write to the type word (0x004), the low target words or an identification word; a read of the clear-enable window or of a write-only window. The write-only windows are 0x080..0x0FC, 0x280..0x2BC, 0x380..0x3BC, 0x400..0x4FC and 0xD00..0xD7C.
- R4: The type word at 0x004 returns (interrupt count/32 − 1) in bits 4:0 and (CPU count − 1) in bits 7:5. In version-3 mode it also returns (ceil(log2(interrupt count)) − 1) in bits 23:19.
- R5: The control word at 0x000 reads 0x7. Bit 5 is also set while affinity routing is on. A control write turns affinity routing on only in version-3 mode with data bit 5 set, and turns it off otherwise.
- R6: Every accepted control write sets all target masks to 0xFF.
- R7: Set-enable words 0x104..0x11C each cover 32 shared interrupts (word w bit b is vector 32+32w+b). A write ORs the data into the enable bits, and a read returns them. Clear-enable words 0x184..0x19C, with the same bit layout, clear each bit written as 1.
- R8: Low target words 0x800..0x81C read the requesting CPU's one-hot bit in all four bytes.
- R9: Target words 0x820..0x8FC hold one mask byte per shared interrupt. Byte b of word w is vector 32+4w+b. While affinity routing is on they read zero and ignore writes.
- R10: The routing register at 0x6100+8n belongs to vector 32+n. It is live only while affinity routing is on; otherwise it reads zero and ignores writes. A write with data bit 31 set stores 0xFF; otherwise data bits 7:0 are stored. A read returns the mask, with bit 31 set when the mask is 0xFF. Entries beyond the implemented interrupts read zero.
- R11: Config word 0xC00 reads all ones and 0xC04..0xC7C read zero. Writes to config words and to write-only windows succeed and change nothing.
- R12: Identification words return the revision in bits 7:4: 2 at 0xFE8, and 3 at 0x1FE8 and 0xFFE8.
- R13: The cycle after a shared line is high with its enable set, `dlv_valid` is 1 with vector 32+index and that interrupt's mask. The lowest active index wins. Lines whose enable is clear are dropped.
- R14: `req_ready` is always 1. Every accepted request gets exactly one response in the following cycle. Failed requests and writes return zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_v3 | input | 1 | Model strap: 1 = version 3, 0 = version 2 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_addr | input | 16 | Byte offset |
| req_wdata | input | 64 | Write data |
| req_cpu | input | 3 | ID of the issuing CPU |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request failed |
| rsp_rdata | output | 64 | Read data |
| irq_in | input | NUM_IRQ−32 | Shared interrupt lines; bit i is vector 32+i |
| dlv_valid | output | 1 | Delivery request |
| dlv_vector | output | 10 | Delivered vector number |
| dlv_mask | output | 8 | CPU mask for the delivery |

## Verification
The bench targets the mode interplay. It checks that packed target writes are dropped once affinity routing is on; a design that ignored the mode would leave a changed mask visible through the routing register. It checks that a control write rewrites every mask to 0xFF even in version-2 mode, and that bit 5 in version-2 mode never enables routing. It covers the routing read's bit-31 flag, entries past the last implemented interrupt, the last enable word, lowest-index-wins selection, and disabled lines; each of these would show up as a wrong vector, a wrong mask or a spurious delivery. Misaligned, wrong-width, unmapped and read-only accesses are each driven to show that the error response is raised.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

   localparam int ADDR_W = 16;
   localparam int IDX_W  = 10;

   typedef enum logic [3:0] {
      RG_NONE, RG_CTRL, RG_TYPE, RG_SETEN, RG_CLREN, RG_TGT_LO, RG_TGT_HI,
      RG_ROUTE, RG_CFG0, RG_CFGN, RG_SINK, RG_ID_V2, RG_ID_V3
   } region_e;

   typedef struct packed {
      region_e            rg;
      logic [IDX_W-1:0]   idx;
      logic               bad;
   } dec_t;

   function automatic logic [31:0] id_word(input logic [3:0] rev);
      return {24'h0, rev, 4'h0};
   endfunction

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
   import irqd_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              wide,
   output dec_t              dec
);

   logic [ADDR_W-1:0] a;
   assign a = addr;

   always_comb begin
      dec.rg  = RG_NONE;
      dec.idx = '0;
      if (a == 16'h0000)                            dec.rg = RG_CTRL;
      else if (a == 16'h0004)                       dec.rg = RG_TYPE;
      else if (a >= 16'h0104 && a <= 16'h011C) begin
         dec.rg  = RG_SETEN;
         dec.idx = IDX_W'((a - 16'h0104) >> 2);
      end
      else if (a >= 16'h0184 && a <= 16'h019C) begin
         dec.rg  = RG_CLREN;
         dec.idx = IDX_W'((a - 16'h0184) >> 2);
      end
      else if ((a >= 16'h0080 && a <= 16'h00FC) || (a >= 16'h0280 && a <= 16'h02BC) ||
               (a >= 16'h0380 && a <= 16'h03BC) || (a >= 16'h0400 && a <= 16'h04FC) ||
               (a >= 16'h0D00 && a <= 16'h0D7C))  dec.rg = RG_SINK;
      else if (a >= 16'h0800 && a <= 16'h081C)     dec.rg = RG_TGT_LO;
      else if (a >= 16'h0820 && a <= 16'h08FC) begin
         dec.rg  = RG_TGT_HI;
         dec.idx = IDX_W'((a - 16'h0820) >> 2);
      end
      else if (a == 16'h0C00)                       dec.rg = RG_CFG0;
      else if (a >= 16'h0C04 && a <= 16'h0C7C)     dec.rg = RG_CFGN;
      else if (a == 16'h0FE8)                       dec.rg = RG_ID_V2;
      else if (a == 16'h1FE8 || a == 16'hFFE8)     dec.rg = RG_ID_V3;
      else if (a >= 16'h6100 && a <= 16'h7FD8) begin
         dec.rg  = RG_ROUTE;
         dec.idx = IDX_W'((a - 16'h6100) >> 3);
      end
   end

   always_comb begin
      dec.bad = (|a[1:0])
              | (wide != (dec.rg == RG_ROUTE))
              | (dec.rg == RG_NONE)
              | (wr  & (dec.rg inside {RG_TYPE, RG_TGT_LO, RG_ID_V2, RG_ID_V3}))
              | (!wr & (dec.rg inside {RG_SINK, RG_CLREN}));
   end

endmodule

// File: rtl/irqd_store.sv
module irqd_store
   import irqd_pkg::*;
#(
   parameter int NSPI = 224
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v3,
   input  logic                 we,
   input  region_e              rg,
   input  logic [IDX_W-1:0]     idx,
   input  logic [31:0]          wdata,
   output logic [NSPI-1:0]      en_q,
   output logic [NSPI*8-1:0]    mask_flat,
   output logic                 aff_q,
   output logic [31:0]          rd_en,
   output logic [31:0]          rd_tgt,
   output logic [63:0]          rd_route
);

   localparam int NWORD = (NSPI + 31) / 32;
   localparam int NTW   = (NSPI + 3) / 4;
   localparam int EW    = $clog2(NWORD + 1);
   localparam int TWW   = $clog2(NTW + 1);
   localparam int RW    = $clog2(NSPI + 1);
   localparam int PADE  = (2**EW) * 32 - NSPI;
   localparam int PADT  = (2**TWW) * 32 - NSPI * 8;
   localparam int PADR  = (2**RW - NSPI) * 8;
   localparam logic [IDX_W-1:0] NWORD_L = IDX_W'(NWORD);
   localparam logic [IDX_W-1:0] NTW_L   = IDX_W'(NTW);
   localparam logic [IDX_W-1:0] NSPI_L  = IDX_W'(NSPI);

   logic [NSPI-1:0][7:0] mask_q;
   logic                 ctl_we;

   assign ctl_we    = we & (rg == RG_CTRL);
   assign mask_flat = mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      aff_q <= 1'b0;
      else if (ctl_we) aff_q <= v3 & wdata[5];
   end

   for (genvar i = 0; i < NSPI; i++) begin : g_spi
      localparam logic [IDX_W-1:0] EWORD = IDX_W'(i / 32);
      localparam int               EBIT  = i % 32;
      localparam logic [IDX_W-1:0] TWORD = IDX_W'(i / 4);
      localparam int               TBYTE = i % 4;
      localparam logic [IDX_W-1:0] RIDX  = IDX_W'(i);

      always_ff @(posedge clk) begin
         if (!rst_n)
            en_q[i] <= 1'b0;
         else if (we && rg == RG_SETEN && idx == EWORD && wdata[EBIT])
            en_q[i] <= 1'b1;
         else if (we && rg == RG_CLREN && idx == EWORD && wdata[EBIT])
            en_q[i] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n || ctl_we)
            mask_q[i] <= 8'hFF;
         else if (we && rg == RG_TGT_HI && !aff_q && idx == TWORD)
            mask_q[i] <= wdata[TBYTE*8 +: 8];
         else if (we && rg == RG_ROUTE && aff_q && idx == RIDX)
            mask_q[i] <= wdata[31] ? 8'hFF : wdata[7:0];
      end
   end

   logic [2**EW-1:0][31:0]  en_words;
   logic [2**TWW-1:0][31:0] tgt_words;
   logic [2**RW-1:0][7:0]   rt_masks;
   logic [7:0]              rt_sel;

   assign en_words  = {{PADE{1'b0}}, en_q};
   assign tgt_words = {{PADT{1'b0}}, mask_q};
   assign rt_masks  = {{PADR{1'b0}}, mask_q};

   assign rd_en    = (idx < NWORD_L) ? en_words[idx[EW-1:0]]   : 32'h0;
   assign rd_tgt   = (idx < NTW_L)   ? tgt_words[idx[TWW-1:0]] : 32'h0;
   assign rt_sel   = (idx < NSPI_L)  ? rt_masks[idx[RW-1:0]]   : 8'h00;
   assign rd_route = {32'h0, (rt_sel == 8'hFF), 23'h0, rt_sel};

   // R6
   ctl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (&mask_q));

   // R5
   aff_v2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !v3) |=> !aff_q);

   // R9
   tgt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && rg == RG_TGT_HI && aff_q) |=> $stable(mask_q));

   // R10
   route_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && rg == RG_ROUTE && !aff_q) |=> $stable(mask_q));

endmodule

// File: rtl/irqd_deliver.sv
module irqd_deliver #(
   parameter int NSPI    = 224,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSPI-1:0]   irq_in,
   input  logic [NSPI-1:0]   en,
   input  logic [NSPI*8-1:0] mask_flat,
   output logic              dlv_valid,
   output logic [9:0]        dlv_vector,
   output logic [7:0]        dlv_mask
);

   logic [NSPI-1:0][7:0] mask;
   logic                 hit;
   logic [9:0]           vec;
   logic [7:0]           msk;

   assign mask = mask_flat;

   always_comb begin
      hit = 1'b0;
      vec = '0;
      msk = '0;
      for (int i = NSPI - 1; i >= 0; i--) begin
         if (irq_in[i] && en[i]) begin
            hit = 1'b1;
            vec = 10'(32 + i);
            msk = mask[i];
         end
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dlv_valid  <= 1'b0;
            dlv_vector <= '0;
            dlv_mask   <= '0;
         end else begin
            dlv_valid  <= hit;
            dlv_vector <= vec;
            dlv_mask   <= msk;
         end
      end

      // R13
      dlv_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|(irq_in & en)) |=> dlv_valid);

      // R13
      dlv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(irq_in & en)) |=> !dlv_valid);
   end else begin : g_comb
      wire unused_clk = clk ^ rst_n;
      assign dlv_valid  = hit;
      assign dlv_vector = vec;
      assign dlv_mask   = msk;
   end

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
   import irqd_pkg::*;
#(
   parameter int NUM_IRQ = 256,
   parameter int NUM_CPU = 8,
   parameter bit DLV_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_v3,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic                 req_wide,
   input  logic [15:0]          req_addr,
   input  logic [63:0]          req_wdata,
   input  logic [2:0]           req_cpu,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [63:0]          rsp_rdata,
   input  logic [NUM_IRQ-33:0]  irq_in,
   output logic                 dlv_valid,
   output logic [9:0]           dlv_vector,
   output logic [7:0]           dlv_mask
);

   localparam int NSPI = NUM_IRQ - 32;
   localparam logic [31:0] TYPE_V2 = 32'((NUM_IRQ / 32 - 1) | ((NUM_CPU - 1) << 5));
   localparam logic [31:0] TYPE_V3 = TYPE_V2 | 32'(($clog2(NUM_IRQ) - 1) << 19);

   if (NUM_IRQ % 32 != 0 || NUM_IRQ < 64 || NUM_IRQ > 1024) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 32 in 64..1024");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be 1..8");
   end

   dec_t         dec;
   logic         we;
   logic [NSPI-1:0]   en_q;
   logic [NSPI*8-1:0] mask_flat;
   logic         aff_q;
   logic [31:0]  rd_en, rd_tgt;
   logic [63:0]  rd_route, rd;
   logic [7:0]   cpu_bit;
   wire          unused_hi = ^req_wdata[63:32];

   assign req_ready = 1'b1;
   assign we        = req_valid & req_write & !dec.bad;
   assign cpu_bit   = 8'd1 << req_cpu;

   irqd_decode i_decode (
      .addr (req_addr),
      .wr   (req_write),
      .wide (req_wide),
      .dec  (dec)
   );

   irqd_store #(.NSPI(NSPI)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .v3        (mode_v3),
      .we        (we),
      .rg        (dec.rg),
      .idx       (dec.idx),
      .wdata     (req_wdata[31:0]),
      .en_q      (en_q),
      .mask_flat (mask_flat),
      .aff_q     (aff_q),
      .rd_en     (rd_en),
      .rd_tgt    (rd_tgt),
      .rd_route  (rd_route)
   );

   irqd_deliver #(.NSPI(NSPI), .REG_OUT(DLV_REG)) i_deliver (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_in     (irq_in),
      .en         (en_q),
      .mask_flat  (mask_flat),
      .dlv_valid  (dlv_valid),
      .dlv_vector (dlv_vector),
      .dlv_mask   (dlv_mask)
   );

   always_comb begin
      case (dec.rg)
         RG_CTRL:   rd = 64'(32'h7 | ((mode_v3 && aff_q) ? 32'h20 : 32'h0));
         RG_TYPE:   rd = 64'(mode_v3 ? TYPE_V3 : TYPE_V2);
         RG_SETEN:  rd = 64'(rd_en);
         RG_TGT_LO: rd = 64'({4{cpu_bit}});
         RG_TGT_HI: rd = aff_q ? 64'h0 : 64'(rd_tgt);
         RG_ROUTE:  rd = aff_q ? rd_route : 64'h0;
         RG_CFG0:   rd = 64'hFFFF_FFFF;
         RG_ID_V2:  rd = 64'(id_word(4'd2));
         RG_ID_V3:  rd = 64'(id_word(4'd3));
         default:   rd = 64'h0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid & dec.bad;
         rsp_rdata <= (req_valid && !req_write && !dec.bad) ? rd : 64'h0;
      end
   end

   // R14
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R14
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R2
   misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);

   // R3
   type_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == 16'h0004) |=> rsp_err);

   // R8
   tgt_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !req_wide && req_addr == 16'h0800)
         |=> rsp_rdata[7:0] == (8'd1 << $past(req_cpu)));

endmodule

// File: tb/test_irq_dist_regs.sv
`timescale 1ns/1ps
module test_irq_dist_regs;

   localparam int NUM_IRQ = 256;
   localparam int NSPI    = NUM_IRQ - 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_v3 = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
   logic [15:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [2:0]  req_cpu = '0;
   logic req_ready, rsp_valid, rsp_err;
   logic [63:0] rsp_rdata;
   logic [NSPI-1:0] irq_in = '0;
   logic dlv_valid;
   logic [9:0] dlv_vector;
   logic [7:0] dlv_mask;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   irq_dist_regs #(.NUM_IRQ(NUM_IRQ)) i_irq_dist_regs (
      .clk(clk), .rst_n(rst_n), .mode_v3(mode_v3),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .irq_in(irq_in), .dlv_valid(dlv_valid),
      .dlv_vector(dlv_vector), .dlv_mask(dlv_mask)
   );

   typedef struct {
      logic        rd;
      logic        err;
      logic [63:0] data;
      string       tag;
   } exp_t;

   exp_t sb[$];

   // Driver: one request, expectation pushed to the scoreboard
   task automatic access(input logic wr, input logic wide, input logic [15:0] addr,
                         input logic [63:0] wd, input logic [2:0] cpu,
                         input logic xerr, input logic [63:0] xdata, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_wide = wide;
      req_addr = addr; req_wdata = wd; req_cpu = cpu;
      e.rd = !wr; e.err = xerr; e.data = xdata; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic rd32(input logic [15:0] addr, input logic [63:0] x, input string tag);
      access(1'b0, 1'b0, addr, 64'h0, 3'd0, 1'b0, x, tag);
   endtask
   task automatic wr32(input logic [15:0] addr, input logic [63:0] d, input string tag);
      access(1'b1, 1'b0, addr, d, 3'd0, 1'b0, 64'h0, tag);
   endtask
   task automatic rd64(input logic [15:0] addr, input logic [63:0] x, input string tag);
      access(1'b0, 1'b1, addr, 64'h0, 3'd0, 1'b0, x, tag);
   endtask
   task automatic wr64(input logic [15:0] addr, input logic [63:0] d, input string tag);
      access(1'b1, 1'b1, addr, d, 3'd0, 1'b0, 64'h0, tag);
   endtask

   // Monitor: pops and compares each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R14 unexpected response: actual valid=1 expected none");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_err !== e.err) begin
               errors++;
               $display("FAIL %s: err actual=%0b expected=%0b", e.tag, rsp_err, e.err);
            end else if (e.rd && !e.err && rsp_rdata !== e.data) begin
               errors++;
               $display("FAIL %s: data actual=%h expected=%h", e.tag, rsp_rdata, e.data);
            end
         end
      end
   end

   task automatic dlv_chk(input int a, input int b, input logic xv,
                          input logic [9:0] xvec, input logic [7:0] xm, input string tag);
      @(negedge clk);
      irq_in = '0;
      if (a >= 0) irq_in[a] = 1'b1;
      if (b >= 0) irq_in[b] = 1'b1;
      @(negedge clk);
      checks++;
      if (dlv_valid !== xv || (xv && (dlv_vector !== xvec || dlv_mask !== xm))) begin
         errors++;
         $display("FAIL %s: actual v=%0b vec=%0d mask=%h expected v=%0b vec=%0d mask=%h",
                  tag, dlv_valid, dlv_vector, dlv_mask, xv, xvec, xm);
      end
      irq_in = '0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || dlv_valid !== 1'b0 || req_ready !== 1'b1) begin
         errors++;
         $display("FAIL R1 idle after reset: actual rsp=%0b dlv=%0b rdy=%0b expected 0 0 1",
                  rsp_valid, dlv_valid, req_ready);
      end
      rd32(16'h0104, 64'h0, "R1 enables clear");
      rd32(16'h0820, 64'hFFFF_FFFF, "R1 masks 0xFF");
      rd32(16'h0000, 64'h7, "R1 routing off");
      dlv_chk(0, 5, 1'b0, 10'd0, 8'h0, "R1 no delivery with enables clear");

      rd32(16'h0004, 64'h0000_00E7, "R4 type v2");

      wr32(16'h0104, 64'h5, "R7 set-enable write");
      wr32(16'h0104, 64'h100, "R7 set-enable second write");
      rd32(16'h0104, 64'h105, "R7 set-enable OR");
      wr32(16'h0184, 64'h4, "R7 clear-enable write");
      rd32(16'h0104, 64'h101, "R7 clear-enable result");
      wr32(16'h011C, 64'h8000_0000, "R7 last word write");
      rd32(16'h011C, 64'h8000_0000, "R7 last word read");

      wr32(16'h0820, 64'h0403_0201, "R9 target write");
      rd32(16'h0820, 64'h0403_0201, "R9 target read");

      dlv_chk(0, 8, 1'b1, 10'd32, 8'h01, "R13 lowest index wins");
      dlv_chk(8, -1, 1'b1, 10'd40, 8'hFF, "R13 single line");
      dlv_chk(2, -1, 1'b0, 10'd0, 8'h0, "R13 disabled dropped");
      dlv_chk(223, -1, 1'b1, 10'd255, 8'hFF, "R13 last vector");
      dlv_chk(-1, -1, 1'b0, 10'd0, 8'h0, "R13 no lines");

      access(1'b0, 1'b0, 16'h0106, 64'h0, 3'd0, 1'b1, 64'h0, "R2 misaligned");
      access(1'b0, 1'b1, 16'h0104, 64'h0, 3'd0, 1'b1, 64'h0, "R2 wide on 32-bit word");
      access(1'b0, 1'b0, 16'h6100, 64'h0, 3'd0, 1'b1, 64'h0, "R2 narrow on routing");
      access(1'b0, 1'b0, 16'h0200, 64'h0, 3'd0, 1'b1, 64'h0, "R3 unmapped");
      access(1'b1, 1'b0, 16'h0004, 64'h0, 3'd0, 1'b1, 64'h0, "R3 type write");
      access(1'b1, 1'b0, 16'h0800, 64'h0, 3'd0, 1'b1, 64'h0, "R3 low target write");
      access(1'b1, 1'b0, 16'h0FE8, 64'h0, 3'd0, 1'b1, 64'h0, "R3 id write");
      access(1'b0, 1'b0, 16'h0400, 64'h0, 3'd0, 1'b1, 64'h0, "R3 write-only read");
      access(1'b0, 1'b0, 16'h0184, 64'h0, 3'd0, 1'b1, 64'h0, "R3 clear-enable read");

      wr32(16'h0400, 64'hFFFF_FFFF, "R11 priority write accepted");
      wr32(16'h0280, 64'hFFFF_FFFF, "R11 pending write accepted");
      wr32(16'h0C04, 64'hFFFF_FFFF, "R11 config write accepted");
      rd32(16'h0C00, 64'hFFFF_FFFF, "R11 config 0 all ones");
      rd32(16'h0C04, 64'h0, "R11 config n zero");
      rd32(16'h0104, 64'h101, "R11 enables untouched");
      rd32(16'h0820, 64'h0403_0201, "R11 masks untouched");

      access(1'b0, 1'b0, 16'h0800, 64'h0, 3'd3, 1'b0, 64'h0808_0808, "R8 cpu 3");
      access(1'b0, 1'b0, 16'h081C, 64'h0, 3'd0, 1'b0, 64'h0101_0101, "R8 cpu 0");
      access(1'b0, 1'b0, 16'h0804, 64'h0, 3'd7, 1'b0, 64'h8080_8080, "R8 cpu 7");

      rd32(16'h0FE8, 64'h20, "R12 id v2");
      rd32(16'h1FE8, 64'h30, "R12 id alt");
      rd32(16'hFFE8, 64'h30, "R12 id v3");

      rd64(16'h6100, 64'h0, "R10 routing off reads zero");
      wr64(16'h6100, 64'h3, "R10 routing off write");
      rd32(16'h0820, 64'h0403_0201, "R10 routing off write ignored");

      wr32(16'h0000, 64'h20, "R5 control write v2");
      rd32(16'h0000, 64'h7, "R5 v2 stays legacy");
      rd32(16'h0820, 64'hFFFF_FFFF, "R6 masks reset by control write");

      @(negedge clk);
      mode_v3 = 1'b1;
      rd32(16'h0004, 64'h0038_00E7, "R4 type v3");
      rd32(16'h0000, 64'h7, "R5 v3 before enable");
      wr32(16'h0820, 64'h0403_0201, "R9 target write before routing");
      wr32(16'h0000, 64'h20, "R5 enable routing");
      rd32(16'h0000, 64'h27, "R5 control shows routing");
      rd32(16'h0820, 64'h0, "R9 target reads zero in routing");
      wr32(16'h0820, 64'h1111_1111, "R9 target write in routing");
      rd64(16'h6100, 64'h8000_00FF, "R6 R9 mask 0xFF after enable, target write ignored");
      wr64(16'h6100, 64'h5, "R10 route write");
      rd64(16'h6100, 64'h5, "R10 route read");
      wr64(16'h6108, 64'h8000_0000, "R10 route all-cpu write");
      rd64(16'h6108, 64'h8000_00FF, "R10 route all-cpu read");
      wr64(16'h6110, 64'h1_0000_0133, "R10 route low byte");
      rd64(16'h6110, 64'h33, "R10 route low byte read");
      rd64(16'h6800, 64'h0, "R10 beyond last interrupt");
      dlv_chk(0, -1, 1'b1, 10'd32, 8'h05, "R13 routed mask");
      dlv_chk(8, 2, 1'b1, 10'd40, 8'hFF, "R13 routed disabled skip");

      wr32(16'h0000, 64'h0, "R5 routing off");
      rd32(16'h0000, 64'h7, "R5 control legacy again");
      rd32(16'h0820, 64'hFFFF_FFFF, "R6 masks reset again");
      rd64(16'h6100, 64'h0, "R10 routing reads zero again");

      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R14 missing responses: actual pending=%0d expected 0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R14 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule